// File: doc/BRIEF.md
# Frequency Lock Window Detector

This block watches a recovered oscillator clock against a reference clock and decides whether the loop is running close enough to the expected frequency. Both clocks arrive as one-cycle enable pulses in a single system clock domain. A gate of `2^GATE_LOG2` reference ticks defines each measurement. Over that gate the oscillator ticks are counted and compared with `RATIO` times the gate length. The comparison uses one of two tolerance windows, 500 ppm or 2000 ppm, chosen by `wide_win`.

Each measurement that falls inside the window moves the block toward lock, and lock is declared after two such results in a row. A measurement outside the window clears lock at once and starts a kick-back phase. During that phase `kick_back` tells the loop to return to the reference frequency. It lasts a fixed number of gate periods. After it ends, the loop is left to hunt for data again and a fresh measurement begins. A low `locked` output is the loss-of-lock report.

Top module: `flw_lock_detector`

## Requirements
- R1: After a synchronous reset, `locked`, `kick_back` and `meas_done` are all 0.
- R2: A measurement ends in the cycle that carries the `2^GATE_LOG2`-th reference tick of the gate, and oscillator ticks in that cycle are counted. `meas_done` is 1 for exactly one cycle, the cycle after that tick.
- R3: With `wide_win`=0, a measurement passes when the oscillator count differs from `RATIO*2^GATE_LOG2` by at most round(`RATIO*2^GATE_LOG2`*500e-6) counts. That is 33 counts at the default gate and 1 count at a gate of 2^9 with ratio 4. `meas_pass` gives the result while `meas_done` is 1.
- R4: With `wide_win`=1, the allowed difference is round(`RATIO*2^GATE_LOG2`*2000e-6) counts: 131 at the default gate and 4 at a gate of 2^9 with ratio 4.
- R5: Only the value of `wide_win` in the gate's final cycle chooses the window for that measurement.
- R6: `locked` rises together with the `meas_done` of the second consecutive passing measurement. It stays 1 while further measurements pass.
- R7: A failing measurement drives `locked` to 0 and `kick_back` to 1 in the same cycle that `meas_done` reports the failure.
- R8: `kick_back` stays 1 for `KICK_GATES*2^GATE_LOG2` reference ticks after the failing tick and falls in the cycle after the last of them. No `meas_done` is produced while it is high.
- R9: After a kick-back the first measurement starts from an empty count. Two new passes are needed before `locked` rises again.
- R10: The oscillator count saturates at its maximum instead of wrapping. A gate whose true count would wrap back into the window still fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One pulse per reference clock cycle |
| osc_tick | input | 1 | One pulse per recovered oscillator cycle |
| wide_win | input | 1 | Window select: 0 = 500 ppm, 1 = 2000 ppm |
| locked | output | 1 | Lock declared (low = loss of lock) |
| kick_back | output | 1 | Force loop to the reference frequency |
| meas_done | output | 1 | One-cycle pulse when a measurement completes |
| meas_pass | output | 1 | Result of the completed measurement |

## Verification
Gates are driven with a controlled count offset. Reference periods are stretched to raise the oscillator count, and oscillator pulses are dropped to lower it. Directed gates sit exactly on each window edge and one count past it, in both directions and in both windows. These gates separate an off-by-one or a sign error in the comparison from a correct one. Further gates do the following:
- switch the window select only in the final cycle, to show which cycle it is sampled in;
- stall the reference long enough that a wrapping counter would land back inside the window;
- repeat failures, to measure the kick-back length in gates.

A seeded random mix of offsets and window choices then runs the pass, lock and kick-back sequence through orderings the directed cases do not reach.

// File: rtl/flw_pkg.sv
package flw_pkg;

    typedef enum logic [0:0] {
        ST_MEASURE = 1'b0,
        ST_KICK    = 1'b1
    } flw_state_e;

    typedef struct packed {
        logic done;
        logic pass;
    } flw_result_t;

    // Allowed count error for a window in ppm, rounded to nearest count.
    function automatic int unsigned tol_count(input int unsigned gate,
                                              input int unsigned ratio,
                                              input int unsigned ppm);
        longint unsigned prod;
        prod = longint'(gate) * longint'(ratio) * longint'(ppm) + 64'd500000;
        return int'(prod / 64'd1000000);
    endfunction

endpackage

// File: rtl/flw_gate_counter.sv
module flw_gate_counter #(
    parameter int GATE_LOG2 = 14
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_tick,
    output logic terminal
);
    logic [GATE_LOG2-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (ref_tick)
            cnt_q <= cnt_q + 1'b1;
    end

    assign terminal = ref_tick && (cnt_q == '1);

    // R2: the gate position only moves on a reference tick
    assert_gate_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !ref_tick |=> $stable(cnt_q));
    // R2: a gate ends and the next starts at zero
    assert_gate_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        terminal |=> cnt_q == '0);

endmodule

// File: rtl/flw_osc_counter.sv
module flw_osc_counter #(
    parameter int CW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          osc_tick,
    input  logic          clear,
    output logic [CW-1:0] count
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (osc_tick && (cnt_q != '1))
            cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;

    // R10: a full counter never wraps to a small value unless cleared
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '1) && !clear |=> cnt_q == '1);

endmodule

// File: rtl/flw_window_cmp.sv
module flw_window_cmp #(
    parameter int          CW    = 18,
    parameter int unsigned NOM   = 65536,
    parameter int unsigned TOL_N = 33,
    parameter int unsigned TOL_W = 131
) (
    input  logic [CW-1:0] count,
    input  logic          osc_tick,
    input  logic          wide_win,
    output logic          in_window
);
    localparam logic [CW:0] NOM_V   = (CW+1)'(NOM);
    localparam logic [CW:0] TOL_N_V = (CW+1)'(TOL_N);
    localparam logic [CW:0] TOL_W_V = (CW+1)'(TOL_W);

    logic [CW:0] total;
    logic [CW:0] diff;
    logic [CW:0] tol;

    always_comb begin
        total = {1'b0, count} + {{CW{1'b0}}, osc_tick};
        if (total >= NOM_V)
            diff = total - NOM_V;
        else
            diff = NOM_V - total;
        tol       = wide_win ? TOL_W_V : TOL_N_V;
        in_window = (diff <= tol);
    end

    // R3/R4: the nominal count always lies inside either window
    assert_nominal_in_R3: assert final (!(total == NOM_V) || in_window);

endmodule

// File: rtl/flw_lock_fsm.sv
module flw_lock_fsm
    import flw_pkg::*;
#(
    parameter int KICK_GATES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        terminal,
    input  logic        in_window,
    output logic        measuring,
    output flw_result_t result,
    output logic        locked,
    output logic        kick_back
);
    localparam int KW = $clog2(KICK_GATES) + 1;
    localparam logic [KW-1:0] KLAST = KW'(KICK_GATES - 1);

    flw_state_e  state_q;
    logic [1:0]  streak_q;
    logic [KW-1:0] kgate_q;
    flw_result_t res_q;
    logic        lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_MEASURE;
            streak_q <= '0;
            kgate_q  <= '0;
            res_q    <= '0;
            lock_q   <= 1'b0;
        end else begin
            res_q.done <= 1'b0;
            unique case (state_q)
                ST_MEASURE: begin
                    if (terminal) begin
                        res_q.done <= 1'b1;
                        res_q.pass <= in_window;
                        if (in_window) begin
                            if (streak_q != 2'd2)
                                streak_q <= streak_q + 1'b1;
                            lock_q <= (streak_q != 2'd0);
                        end else begin
                            streak_q <= '0;
                            lock_q   <= 1'b0;
                            kgate_q  <= '0;
                            state_q  <= ST_KICK;
                        end
                    end
                end
                ST_KICK: begin
                    if (terminal) begin
                        if (kgate_q == KLAST)
                            state_q <= ST_MEASURE;
                        else
                            kgate_q <= kgate_q + 1'b1;
                    end
                end
                default: state_q <= ST_MEASURE;
            endcase
        end
    end

    assign measuring = (state_q == ST_MEASURE);
    assign kick_back = (state_q == ST_KICK);
    assign result    = res_q;
    assign locked    = lock_q;

    // R7: lock and kick-back never coexist
    assert_lock_excl_R7: assert property (@(posedge clk) disable iff (rst)
        lock_q |-> !kick_back);
    // R7: a failing report always comes with kick-back
    assert_fail_kicks_R7: assert property (@(posedge clk) disable iff (rst)
        res_q.done && !res_q.pass |-> kick_back);
    // R8: no report while kick-back was already running
    assert_quiet_kick_R8: assert property (@(posedge clk) disable iff (rst)
        kick_back && $past(kick_back) |-> !res_q.done);
    // R8: kick-back ends only on a reference gate boundary
    assert_kick_end_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(kick_back) |-> $past(terminal));
    // R6: lock only rises with a passing report
    assert_lock_rise_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_q) |-> res_q.done && res_q.pass);

endmodule

// File: rtl/flw_lock_detector.sv
module flw_lock_detector
    import flw_pkg::*;
#(
    parameter int GATE_LOG2  = 14,
    parameter int RATIO      = 4,
    parameter int PPM_NARROW = 500,
    parameter int PPM_WIDE   = 2000,
    parameter int KICK_GATES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_tick,
    input  logic osc_tick,
    input  logic wide_win,
    output logic locked,
    output logic kick_back,
    output logic meas_done,
    output logic meas_pass
);
    localparam int unsigned GATE  = 1 << GATE_LOG2;
    localparam int          CW    = GATE_LOG2 + $clog2(RATIO) + 2;
    localparam int unsigned NOM   = GATE * RATIO;
    localparam int unsigned TOL_N = tol_count(GATE, RATIO, PPM_NARROW);
    localparam int unsigned TOL_W = tol_count(GATE, RATIO, PPM_WIDE);

    logic          terminal;
    logic          measuring;
    logic          in_window;
    logic [CW-1:0] osc_count;
    flw_result_t   result;

    flw_gate_counter #(.GATE_LOG2(GATE_LOG2)) u_gate (
        .clk      (clk),
        .rst      (rst),
        .ref_tick (ref_tick),
        .terminal (terminal)
    );

    flw_osc_counter #(.CW(CW)) u_osc (
        .clk      (clk),
        .rst      (rst),
        .osc_tick (osc_tick),
        .clear    (terminal || !measuring),
        .count    (osc_count)
    );

    flw_window_cmp #(
        .CW    (CW),
        .NOM   (NOM),
        .TOL_N (TOL_N),
        .TOL_W (TOL_W)
    ) u_cmp (
        .count     (osc_count),
        .osc_tick  (osc_tick),
        .wide_win  (wide_win),
        .in_window (in_window)
    );

    flw_lock_fsm #(.KICK_GATES(KICK_GATES)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .terminal  (terminal),
        .in_window (in_window),
        .measuring (measuring),
        .result    (result),
        .locked    (locked),
        .kick_back (kick_back)
    );

    assign meas_done = result.done;
    assign meas_pass = result.pass;

    // R2: a report is a single-cycle pulse
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        meas_done |=> !meas_done);
    // R9: the count is empty while kick-back holds the loop
    assert_kick_empty_R9: assert property (@(posedge clk) disable iff (rst)
        kick_back && $past(kick_back) |-> osc_count == '0);

endmodule

// File: tb/flw_lock_detector_tb.sv
`timescale 1ns/1ps
module flw_lock_detector_tb;
    localparam int GL   = 9;
    localparam int G    = 1 << GL;
    localparam int RAT  = 4;
    localparam int KG   = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_tick = 1'b0, osc_tick = 1'b0, wide_win = 1'b0;
    logic locked, kick_back, meas_done, meas_pass;

    int n_chk = 0, n_fail = 0;
    int streak = 0, kick_left = 0, post_kick = 0;
    logic m_lock = 1'b0;
    bit pend = 0, pend2 = 0, done_flag = 0;
    logic e_done, e_pass, e_lock, e_kick;
    string e_ptag, e_ltag;

    always #2.5 clk = ~clk;

    flw_lock_detector #(.GATE_LOG2(GL), .RATIO(RAT), .KICK_GATES(KG)) u_dut (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .osc_tick(osc_tick),
        .wide_win(wide_win), .locked(locked), .kick_back(kick_back),
        .meas_done(meas_done), .meas_pass(meas_pass));

    function automatic int tol(input logic wide);
        real ppm;
        ppm = wide ? 2000.0 : 500.0;
        return $rtoi(real'(RAT * G) * ppm / 1.0e6 + 0.5);
    endfunction

    function automatic logic exp_pass(input int dev, input logic wide);
        int a;
        a = (dev < 0) ? -dev : dev;
        if (RAT * G + dev >= (1 << (GL + 4))) return 1'b0;
        return (a <= tol(wide)) ? 1'b1 : 1'b0;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic o, input logic w);
        @(posedge clk); #1;
        if (pend) begin
            pend = 0;
            chk({"R2 done ", e_ptag}, meas_done, e_done);
            if (e_done) chk({e_ptag, " pass"}, meas_pass, e_pass);
            chk({e_ltag, " lock"}, locked, e_lock);
            chk({e_ptag == "R8" ? "R8" : "R7", " kick"}, kick_back, e_kick);
            pend2 = e_done;
        end else if (pend2) begin
            pend2 = 0;
            chk("R2 one-cycle pulse", meas_done, 1'b0);
        end
        ref_tick = r; osc_tick = o; wide_win = w;
    endtask

    // Drive one gate whose oscillator count is RAT*G + dev.
    task automatic gate(input int dev, input logic wb, input logic we, input string tag);
        int up, dn, c;
        logic p;
        up = (dev > 0) ? dev : 0;
        dn = (dev < 0) ? -dev : 0;
        c = 0;
        for (int k = 0; k < G; k++) begin
            int per;
            per = RAT + up / G + ((k < up % G) ? 1 : 0);
            for (int j = 0; j < per; j++) begin
                logic last;
                last = (j == per - 1);
                step(last, (c >= dn), (last && k == G - 1) ? we : wb);
                c++;
            end
        end
        e_ltag = (post_kick > 0) ? "R9" : "R6";
        if (kick_left > 0) begin
            kick_left--;
            e_done = 0; e_pass = 0; e_lock = 0;
            e_kick = (kick_left > 0);
            e_ptag = "R8";
            if (kick_left == 0) post_kick = 2;
        end else begin
            p = exp_pass(dev, we);
            e_done = 1; e_pass = p; e_ptag = tag;
            if (post_kick > 0) post_kick--;
            if (p) begin
                streak = (streak < 2) ? streak + 1 : 2;
                m_lock = (streak >= 2);
                e_kick = 0;
            end else begin
                streak = 0; m_lock = 0;
                kick_left = KG;
                e_kick = 1;
            end
            e_lock = m_lock;
        end
        pend = 1;
    endtask

    task automatic drain_kick();
        while (kick_left > 0) gate(0, 1'b0, 1'b0, "R8");
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 locked", locked, 1'b0);
        chk("R1 kick_back", kick_back, 1'b0);
        chk("R1 meas_done", meas_done, 1'b0);

        gate(0, 0, 0, "R3");          // pass, no lock yet
        gate(0, 0, 0, "R6");          // second pass, lock
        gate(1, 0, 0, "R3");          // narrow edge, high side
        gate(-1, 0, 0, "R3");         // narrow edge, low side
        gate(2, 0, 0, "R3");          // one past narrow edge
        drain_kick();
        gate(4, 1, 1, "R4");          // wide edge, fresh after kick
        gate(-4, 1, 1, "R4");
        gate(-5, 1, 1, "R4");         // one past wide edge
        drain_kick();
        gate(3, 1, 0, "R5");          // wide in body, narrow at end: fail
        drain_kick();
        gate(3, 0, 1, "R5");          // narrow in body, wide at end: pass
        gate(-2, 1, 1, "R4");
        gate(8192, 0, 1, "R10");      // would wrap to nominal
        drain_kick();
        for (int i = 0; i < 14; i++) begin
            int d;
            logic w;
            d = int'($urandom_range(12)) - 6;
            w = 1'($urandom_range(1));
            gate(d, w, w, w ? "R4" : "R3");
            drain_kick();
        end
        step(0, 0, 0);
        step(0, 0, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule